// File: doc/BRIEF.md
# Byte-Writable Synchronous Burst SRAM Core

This block is a single-port synchronous memory whose word holds four 9-bit byte lanes. It has a parameterised depth. The word address for each access comes from an internal burst address generator. A load cycle takes a new base address. Later cycles either repeat the current word or step through an aligned block of four words, in linear or interleaved order.

A cycle writes either all four lanes through a global write, or only the lanes picked by per-byte selects while a byte-write enable is active. A selected cycle with no write request is a read. A mode input picks the read path:
- With the registered path, data appears one cycle after the command.
- With the straight-through path, data appears in the same cycle as the command.

An asynchronous output enable gates a data-valid flag. An asynchronous sleep input blocks all accesses while the array keeps its contents.

Top module: `sram_bytewr_core`

## Requirements
- R1: When gw_n is low on a selected cycle, all four 9-bit lanes of the addressed word take wdata, whatever bwe_n and bsel_n are.
- R2: When gw_n is high and bwe_n is low, only the lanes i with bsel_n[i] low are written; lane i is wdata[9*i+8:9*i]. The other lanes keep their old contents.
- R3: A selected cycle with gw_n high and no byte write (bwe_n high, or all bsel_n high) is a read and leaves the array unchanged.
- R4: With pipe_mode low, the read word and rvalid high appear right after the clock edge that samples the read command.
- R5: With pipe_mode high, the read word and rvalid appear one clock edge later than in R4.
- R6: A cycle with ld high takes addr as the access address and starts a burst of four. Each later selected cycle with adv high moves to the next burst position and wraps after the fourth. With adv low, the current address is repeated. The bits above the low two come from the loaded base.
- R7: With lin_order high, the low two address bits at burst position i are (base + i) mod 4. With lin_order low, they are base XOR i.
- R8: When oe is low, rvalid is low. A change of oe acts on rvalid without a clock edge.
- R9: A cycle with sel_n high performs no access. No write takes place, and no valid read results from it.
- R10: With pipe_mode high, rdata keeps the last word read while rvalid is low. This holds across cycles with oe low, deselected cycles and write cycles.
- R11: While sleep is high, rvalid is low at once, and every read and write is ignored. After sleep falls, reads return the contents stored before sleep.
- R12: After reset, rvalid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset of control state, active low |
| sel_n | input | 1 | Device select, active low |
| ld | input | 1 | Load addr as burst base |
| adv | input | 1 | Step burst position |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | AW | Word address (AW = log2 DEPTH) |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane byte selects, active low |
| wdata | input | 36 | Write word |
| pipe_mode | input | 1 | 1 = registered read path, 0 = straight-through |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous sleep, active high |
| rdata | output | 36 | Read word |
| rvalid | output | 1 | Read data valid |

## Verification
The hardest case to reach is the held word in the registered read path. It only becomes visible when a read is followed by cycles that must not disturb the output register: oe low, deselect, a write, or sleep. oe must also be toggled between clock edges.

The stimulus therefore interleaves pipelined reads with these cycles. It samples rdata and rvalid with oe low, then raises oe in the middle of a cycle and samples again before any edge arrives. Sleep is entered during a valid straight-through read, a write is attempted while asleep, and the same word is read back after wake-up.

// File: rtl/sram_bw_pkg.sv
package sram_bw_pkg;
    localparam int BYTE_W = 9;
    localparam int NBYTES = 4;
    localparam int WORD_W = BYTE_W * NBYTES;

    typedef struct packed {
        logic              act;
        logic              wr;
        logic [NBYTES-1:0] mask;
    } cmd_t;
endpackage

// File: rtl/sram_burst_gen.sv
module sram_burst_gen #(
    parameter int AW      = 6,
    parameter int BURST_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          ld,
    input  logic          adv,
    input  logic          lin_order,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] cur_addr
);
    typedef struct packed {
        logic [AW-1:0]      base;
        logic [BURST_W-1:0] idx;
    } bst_t;

    bst_t st_d, st_q;
    logic [AW-1:0]      nbase;
    logic [BURST_W-1:0] nidx;
    logic [BURST_W-1:0] lo;

    always_comb begin
        if (ld) begin
            nbase = addr;
            nidx  = '0;
        end else begin
            nbase = st_q.base;
            nidx  = adv ? st_q.idx + 1'b1 : st_q.idx;
        end
        lo       = lin_order ? (nbase[BURST_W-1:0] + nidx) : (nbase[BURST_W-1:0] ^ nidx);
        cur_addr = {nbase[AW-1:BURST_W], lo};
        st_d     = go ? '{base: nbase, idx: nidx} : st_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sram_word_array.sv
module sram_word_array
    import sram_bw_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [NBYTES-1:0] we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rword
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we[g]) mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
        end
        assign rword[g*BYTE_W +: BYTE_W] = mem[raddr];
    end
endmodule

// File: rtl/sram_rd_stage.sv
module sram_rd_stage
    import sram_bw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              oe,
    input  logic              sleep,
    input  logic              rd_in,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    typedef struct packed {
        logic [WORD_W-1:0] pdata;
        logic              pvalid;
    } rst_t;

    rst_t st_d, st_q;
    logic valid_raw;

    always_comb begin
        st_d.pdata  = rd_in ? word_in : st_q.pdata;
        st_d.pvalid = rd_in;
        rdata       = pipe_mode ? st_q.pdata : word_in;
        valid_raw   = pipe_mode ? st_q.pvalid : rd_in;
        rvalid      = valid_raw && oe && !sleep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sram_bytewr_core.sv
module sram_bytewr_core
    import sram_bw_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int BURST_W = 2,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              ld,
    input  logic              adv,
    input  logic              lin_order,
    input  logic [AW-1:0]     addr,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [NBYTES-1:0] bsel_n,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pipe_mode,
    input  logic              oe,
    input  logic              sleep,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    typedef struct packed {
        logic          rd;
        logic [AW-1:0] raddr;
    } cst_t;

    cst_t              st_d, st_q;
    cmd_t              cmd;
    logic [AW-1:0]     cur_addr;
    logic [NBYTES-1:0] we;
    logic [WORD_W-1:0] rword;

    always_comb begin
        cmd.act  = !sel_n && !sleep;
        cmd.mask = !gw_n ? '1 : (!bwe_n ? ~bsel_n : '0);
        cmd.wr   = cmd.act && (|cmd.mask);
        we       = cmd.wr ? cmd.mask : '0;
        st_d.rd    = cmd.act && !cmd.wr;
        st_d.raddr = cmd.act ? cur_addr : st_q.raddr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sram_burst_gen #(.AW(AW), .BURST_W(BURST_W)) burst_i (
        .clk(clk), .rst_n(rst_n), .go(cmd.act), .ld(ld), .adv(adv),
        .lin_order(lin_order), .addr(addr), .cur_addr(cur_addr)
    );

    sram_word_array #(.DEPTH(DEPTH)) array_i (
        .clk(clk), .we(we), .waddr(cur_addr), .wdata(wdata),
        .raddr(st_q.raddr), .rword(rword)
    );

    sram_rd_stage rdst_i (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe(oe), .sleep(sleep),
        .rd_in(st_q.rd), .word_in(rword), .rdata(rdata), .rvalid(rvalid)
    );

    // R1
    global_write_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.act && !gw_n) |=> (rword == $past(wdata)));

    for (genvar g = 0; g < NBYTES; g++) begin : g_bchk
        // R2
        byte_lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd.act && gw_n && !bwe_n && !bsel_n[g])
            |=> (rword[g*BYTE_W +: BYTE_W] == $past(wdata[g*BYTE_W +: BYTE_W])));
    end

    // R4
    flow_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && rvalid) |-> st_q.rd);

    // R5
    pipe_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(pipe_mode) && rvalid) |-> $past(st_q.rd));

    // R8
    oe_gates_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !rvalid);

    // R10
    pipe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(pipe_mode) && !$past(st_q.rd)) |-> $stable(rdata));

    // R11
    sleep_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rvalid);

    // R11
    sleep_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !st_q.rd);
endmodule

// File: tb/sram_bytewr_core_tb_top.sv
module sram_bytewr_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1, ld = 1'b0, adv = 1'b0, lin_order = 1'b1;
    logic [5:0]  addr = '0;
    logic        gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]  bsel_n = 4'hF;
    logic [35:0] wdata = '0;
    logic        pipe_mode = 1'b0, oe = 1'b1, sleep = 1'b0;
    logic [35:0] rdata;
    logic        rvalid;

    int checks = 0;
    int fails  = 0;
    logic [35:0] model [64];

    always #10 clk = ~clk;

    sram_bytewr_core dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ld(ld), .adv(adv),
        .lin_order(lin_order), .addr(addr), .gw_n(gw_n), .bwe_n(bwe_n),
        .bsel_n(bsel_n), .wdata(wdata), .pipe_mode(pipe_mode), .oe(oe),
        .sleep(sleep), .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [35:0] pat(input int a, input int salt);
        return 36'(a * 36'h013579BDF + salt * 36'h90F0F0F0F + 36'h123);
    endfunction

    function automatic logic [5:0] bpos(input logic [5:0] base, input int i, input logic lin);
        logic [1:0] lo;
        lo = lin ? 2'(base[1:0] + 2'(i)) : (base[1:0] ^ 2'(i));
        return {base[5:2], lo};
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic s_n, input logic l, input logic a_v, input logic [5:0] ad,
                       input logic g_n, input logic b_n, input logic [3:0] bs, input logic [35:0] wd);
        sel_n = s_n; ld = l; adv = a_v; addr = ad;
        gw_n = g_n; bwe_n = b_n; bsel_n = bs; wdata = wd;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a);
        cyc(1'b0, 1'b1, 1'b0, a, 1'b1, 1'b1, 4'hF, '0);
    endtask

    task automatic desel();
        cyc(1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1, 4'hF, '0);
    endtask

    initial begin
        #(20ns * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 36'd0, 36'd1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [35:0] m;
        @(negedge clk);
        @(negedge clk);
        chk("R12 rvalid in reset", {35'd0, rvalid}, 36'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 rvalid after reset", {35'd0, rvalid}, 36'd0);

        // R1: global write over all addresses, byte controls varied and ignored
        for (int a = 0; a < 64; a++) begin
            cyc(1'b0, 1'b1, 1'b0, 6'(a), 1'b0, 1'(a[4]), 4'(a), pat(a, 1));
            model[a] = pat(a, 1);
        end
        // R4: straight-through read of every word
        for (int a = 0; a < 64; a++) begin
            rd(6'(a));
            chk("R1/R4 flow read data", rdata, model[a]);
            chk("R4 flow read valid", {35'd0, rvalid}, 36'd1);
        end

        // R2: all 16 byte-select patterns; R3: all-high selects are a read
        for (int a = 0; a < 16; a++) begin
            cyc(1'b0, 1'b1, 1'b0, 6'(a), 1'b1, 1'b0, 4'(a), pat(a, 7));
            m = pat(a, 7);
            for (int b = 0; b < 4; b++)
                if (!a[b]) model[a][b*9 +: 9] = m[b*9 +: 9];
        end
        // R3: byte selects with bwe_n high do nothing
        for (int a = 16; a < 20; a++)
            cyc(1'b0, 1'b1, 1'b0, 6'(a), 1'b1, 1'b1, 4'h0, pat(a, 9));
        for (int a = 0; a < 20; a++) begin
            rd(6'(a));
            chk("R2/R3 byte write readback", rdata, model[a]);
        end

        // R9: deselected write is dropped
        cyc(1'b1, 1'b1, 1'b0, 6'd7, 1'b0, 1'b1, 4'h0, 36'hFFFFFFFFF);
        chk("R9 deselect no valid", {35'd0, rvalid}, 36'd0);
        rd(6'd7);
        chk("R9 deselect no write", rdata, model[7]);

        // R6/R7: bursts from each base offset, both orders
        for (int lin = 0; lin < 2; lin++) begin
            for (int lo = 0; lo < 4; lo++) begin
                lin_order = 1'(lin);
                rd(6'(40 + lo));
                chk("R6 burst load", rdata, model[40 + lo]);
                for (int i = 1; i <= 4; i++) begin
                    cyc(1'b0, 1'b0, 1'b1, 6'd0, 1'b1, 1'b1, 4'hF, '0);
                    chk("R6/R7 burst step", rdata, model[bpos(6'(40 + lo), i, 1'(lin))]);
                end
                cyc(1'b0, 1'b0, 1'b0, 6'd0, 1'b1, 1'b1, 4'hF, '0);
                chk("R6 no advance repeats", rdata, model[40 + lo]);
            end
        end

        // R6/R7: burst write, linear from base 6
        lin_order = 1'b1;
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 1'(i == 0), 1'(i != 0), 6'd6, 1'b0, 1'b1, 4'hF, pat(i, 21));
            model[bpos(6'd6, i, 1'b1)] = pat(i, 21);
        end
        for (int a = 4; a < 8; a++) begin
            rd(6'(a));
            chk("R6/R7 burst write readback", rdata, model[a]);
        end

        // R8: asynchronous oe in straight-through mode
        rd(6'd30);
        oe = 1'b0;
        #1;
        chk("R8 oe low hides flow data", {35'd0, rvalid}, 36'd0);
        oe = 1'b1;
        #1;
        chk("R8 oe high shows flow data", {35'd0, rvalid}, 36'd1);

        // R5: registered path, back-to-back reads
        desel();
        pipe_mode = 1'b1;
        for (int a = 0; a < 64; a++) begin
            rd(6'(a));
            if (a == 0) chk("R5 no data in command cycle", {35'd0, rvalid}, 36'd0);
            else        chk("R5 pipe read data", rdata, model[a - 1]);
        end
        desel();
        chk("R5 pipe last read", rdata, model[63]);
        chk("R5 pipe last valid", {35'd0, rvalid}, 36'd1);

        // R10/R8/R9: held word in registered path
        rd(6'd20);
        oe = 1'b0;
        desel();
        chk("R8 pipe oe low", {35'd0, rvalid}, 36'd0);
        chk("R10 held with oe low", rdata, model[20]);
        oe = 1'b1;
        #1;
        chk("R8 pipe oe raised mid-cycle", {35'd0, rvalid}, 36'd1);
        desel();
        chk("R9 pipe deselect valid low", {35'd0, rvalid}, 36'd0);
        chk("R10 held across deselect", rdata, model[20]);
        rd(6'd21);
        cyc(1'b0, 1'b1, 1'b0, 6'd22, 1'b0, 1'b1, 4'hF, pat(22, 3));
        model[22] = pat(22, 3);
        chk("R10 read before write shows", rdata, model[21]);
        desel();
        chk("R10 held across write", rdata, model[21]);
        chk("R10 write gives no valid", {35'd0, rvalid}, 36'd0);

        // R11: sleep in straight-through mode
        pipe_mode = 1'b0;
        rd(6'd3);
        chk("R11 pre-sleep valid", {35'd0, rvalid}, 36'd1);
        sleep = 1'b1;
        #1;
        chk("R11 sleep drops valid at once", {35'd0, rvalid}, 36'd0);
        cyc(1'b0, 1'b1, 1'b0, 6'd3, 1'b0, 1'b1, 4'h0, ~model[3]);
        rd(6'd3);
        chk("R11 read ignored asleep", {35'd0, rvalid}, 36'd0);
        sleep = 1'b0;
        rd(6'd3);
        chk("R11 contents kept", rdata, model[3]);
        chk("R11 valid after wake", {35'd0, rvalid}, 36'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule